// File: doc/BRIEF.md
# Character LCD 4-bit Transfer Sequencer

This block stands in for the driver software of a character LCD controller that is wired with only its upper four data lines. Once reset is released it brings the display up by itself. First come four timed single-nibble wake-up writes. Then come five configuration commands, each sent as a two-nibble byte and each gated by a busy-flag poll. After that the block serves a host that hands over one byte at a time, together with a flag that selects the command register or the character data register.

Each nibble moves in a bus cycle built by a strobe engine. The engine sets register select, read/write and the data nibble first. It then raises enable for a set number of clocks and holds the bus for a set number of clocks after enable falls. Every two-nibble byte is preceded by read cycles that fetch the busy flag. The block drives the data nibble only while it writes. The output value, its enable and the input sample are separate ports, and the tri-state pad is assembled at the chip edge. A poll limit makes sure a display that never reports ready cannot stall the block: when the limit is reached, an error flag is raised and the byte is written anyway.

Top module: `lcd_nibble_seq`

## Requirements
- R1: After reset the block waits WAKE_CYC clocks before each wake-up write. It then writes nibble 0x3 to the command register (register select 0, read/write 0) three times, with no read cycle anywhere in this phase.
- R2: After the three 0x3 nibbles, exactly one single-nibble command 0x2 follows, again preceded by a WAKE_CYC wait and with no busy poll.
- R3: The block then sends the command bytes 0x28, 0x08, 0x01, 0x06, 0x0F in that order. Every byte, whether from initialization or from the host, appears as two nibbles on data lines 7:4, high nibble first.
- R4: Before each two-nibble byte the block reads the command register as a pair of nibbles (register select 0, read/write 1). Bit 3 of the first nibble of the pair is the busy flag. The pair is repeated until that bit reads 0.
- R5: A host byte with host_is_data = 1 is written with register select 1. A host byte with host_is_data = 0 is written with register select 0, and this includes display address commands such as 0x80 and 0xC0.
- R6: host_ready is high only after initialization has finished and while no byte is in progress. host_valid presented before that has no effect. A byte is taken on a clock where host_valid and host_ready are both high, and host_ready is low on the next clock.
- R7: lcd_db_oe is 1 during write cycles and 0 during busy-read cycles.
- R8: In every bus cycle, register select, read/write, data and output enable are stable for at least SETUP_CYC clocks before enable rises. Enable stays high for exactly PULSE_CYC clocks, and the bus holds for at least HOLD_CYC clocks after enable falls.
- R9: If POLL_LIMIT consecutive poll pairs for one byte all report busy, busy_timeout goes to 1 and the byte is written without further polling. POLL_LIMIT-1 busy pairs followed by a clear pair do not set it. busy_timeout stays at 1 until reset.
- R10: During and right after reset, lcd_en, lcd_db_oe, host_ready, init_done and busy_timeout are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_valid | input | 1 | Host offers a byte |
| host_ready | output | 1 | Block can take a byte this clock |
| host_is_data | input | 1 | 1: character data register, 0: command register |
| host_byte | input | 8 | Byte to send |
| init_done | output | 1 | Power-on sequence finished |
| busy_timeout | output | 1 | Sticky: a poll reached POLL_LIMIT busy replies |
| lcd_rs | output | 1 | Register select to the display |
| lcd_rw | output | 1 | 1 read, 0 write |
| lcd_en | output | 1 | Enable strobe |
| lcd_db_out | output | 4 | Nibble driven on data lines 7:4 |
| lcd_db_oe | output | 1 | Output enable for the data pad |
| lcd_db_in | input | 4 | Nibble sampled from data lines 7:4 |

## Verification
The bench builds the block with WAKE_CYC = 20, SETUP_CYC = 2, PULSE_CYC = 3, HOLD_CYC = 1 and POLL_LIMIT = 4. The short wake delay lets the whole power-on sequence finish in a few hundred clocks, so every host case runs after it. A poll limit of 4 puts both sides of the timeout within reach with a handful of busy replies: three busy pairs followed by a clear one, and ten busy replies cut off after four pairs. A two-clock setup separates bus changes from the enable edge far enough for a setup shortfall to show.

// File: rtl/lcd_seq_pkg.sv
package lcd_seq_pkg;

  typedef enum logic [2:0] {
    ST_WAKE,
    ST_WAKE_WR,
    ST_POLL_HI,
    ST_POLL_LO,
    ST_WR_HI,
    ST_WR_LO,
    ST_IDLE
  } seq_state_t;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_SETUP,
    PH_HIGH,
    PH_HOLD
  } strobe_phase_t;

  localparam int WAKE_WRITES = 4;
  localparam int CFG_BYTES   = 5;

  // Single-nibble wake-up writes, issued after a timed delay each.
  function automatic logic [3:0] wake_nibble(input logic [2:0] idx);
    return (idx == 3'd3) ? 4'h2 : 4'h3;
  endfunction

  // Configuration bytes sent once the interface runs on four lines.
  function automatic logic [7:0] cfg_byte(input logic [2:0] idx);
    case (idx)
      3'd0:    return 8'h28;
      3'd1:    return 8'h08;
      3'd2:    return 8'h01;
      3'd3:    return 8'h06;
      default: return 8'h0F;
    endcase
  endfunction

endpackage

// File: rtl/lcd_strobe.sv
module lcd_strobe
  import lcd_seq_pkg::*;
#(
  parameter int SETUP_CYC = 2,
  parameter int PULSE_CYC = 3,
  parameter int HOLD_CYC  = 1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       req_rs,
  input  logic       req_rw,
  input  logic [3:0] req_nib,
  output logic       done,
  output logic [3:0] rd_nib,
  output logic       lcd_rs,
  output logic       lcd_rw,
  output logic       lcd_en,
  output logic [3:0] lcd_db_out,
  output logic       lcd_db_oe,
  input  logic [3:0] lcd_db_in
);

  localparam int MAX_A = (SETUP_CYC > PULSE_CYC) ? SETUP_CYC : PULSE_CYC;
  localparam int MAX_C = (MAX_A > HOLD_CYC) ? MAX_A : HOLD_CYC;
  localparam int CW    = (MAX_C < 2) ? 1 : $clog2(MAX_C);

  strobe_phase_t phase;
  logic [CW-1:0] cnt;

  assign done = (phase == PH_HOLD) && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase      <= PH_IDLE;
      cnt        <= '0;
      lcd_en     <= 1'b0;
      lcd_db_oe  <= 1'b0;
      lcd_rs     <= 1'b0;
      lcd_rw     <= 1'b0;
      lcd_db_out <= 4'h0;
      rd_nib     <= 4'h0;
    end else begin
      case (phase)
        PH_IDLE: begin
          if (start) begin
            lcd_rs     <= req_rs;
            lcd_rw     <= req_rw;
            lcd_db_out <= req_rw ? 4'h0 : req_nib;
            lcd_db_oe  <= !req_rw;
            cnt        <= CW'(SETUP_CYC - 1);
            phase      <= PH_SETUP;
          end
        end
        PH_SETUP: begin
          if (cnt == '0) begin
            lcd_en <= 1'b1;
            cnt    <= CW'(PULSE_CYC - 1);
            phase  <= PH_HIGH;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        PH_HIGH: begin
          if (cnt == '0) begin
            lcd_en <= 1'b0;
            rd_nib <= lcd_db_in;
            cnt    <= CW'(HOLD_CYC - 1);
            phase  <= PH_HOLD;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: begin
          if (cnt == '0) begin
            lcd_db_oe <= 1'b0;
            phase     <= PH_IDLE;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
      endcase
    end
  end

  // R8: the bus does not move while enable is high
  assert_bus_stable_R8: assert property (@(posedge clk) disable iff (rst)
    lcd_en |-> ($stable(lcd_rs) && $stable(lcd_rw) && $stable(lcd_db_out) && $stable(lcd_db_oe)));

  // R7: the data pad is driven only in write cycles
  assert_oe_write_only_R7: assert property (@(posedge clk) disable iff (rst)
    lcd_db_oe |-> !lcd_rw);

endmodule

// File: rtl/lcd_nibble_seq.sv
module lcd_nibble_seq
  import lcd_seq_pkg::*;
#(
  parameter int WAKE_CYC   = 40000,
  parameter int SETUP_CYC  = 2,
  parameter int PULSE_CYC  = 12,
  parameter int HOLD_CYC   = 2,
  parameter int POLL_LIMIT = 1000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       host_valid,
  output logic       host_ready,
  input  logic       host_is_data,
  input  logic [7:0] host_byte,
  output logic       init_done,
  output logic       busy_timeout,
  output logic       lcd_rs,
  output logic       lcd_rw,
  output logic       lcd_en,
  output logic [3:0] lcd_db_out,
  output logic       lcd_db_oe,
  input  logic [3:0] lcd_db_in
);

  localparam int WCW = (WAKE_CYC < 2) ? 1 : $clog2(WAKE_CYC);
  localparam int PCW = (POLL_LIMIT < 2) ? 1 : $clog2(POLL_LIMIT);

  seq_state_t     state;
  logic [WCW-1:0] wake_cnt;
  logic [2:0]     step;
  logic           issued;
  logic [7:0]     cur_byte;
  logic           cur_rs;
  logic           busy_hi;
  logic [PCW-1:0] poll_cnt;

  logic       xfer_state, start, xfer_done, req_rs, req_rw;
  logic [3:0] req_nib, rd_nib;

  always_comb begin
    xfer_state = (state == ST_WAKE_WR) || (state == ST_POLL_HI) || (state == ST_POLL_LO) ||
                 (state == ST_WR_HI) || (state == ST_WR_LO);
    start   = xfer_state && !issued;
    req_rw  = (state == ST_POLL_HI) || (state == ST_POLL_LO);
    req_rs  = ((state == ST_WR_HI) || (state == ST_WR_LO)) ? cur_rs : 1'b0;
    case (state)
      ST_WAKE_WR: req_nib = wake_nibble(step);
      ST_WR_HI:   req_nib = cur_byte[7:4];
      ST_WR_LO:   req_nib = cur_byte[3:0];
      default:    req_nib = 4'h0;
    endcase
  end

  assign host_ready = (state == ST_IDLE);

  lcd_strobe #(
    .SETUP_CYC(SETUP_CYC),
    .PULSE_CYC(PULSE_CYC),
    .HOLD_CYC (HOLD_CYC)
  ) u_strobe (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .req_rs    (req_rs),
    .req_rw    (req_rw),
    .req_nib   (req_nib),
    .done      (xfer_done),
    .rd_nib    (rd_nib),
    .lcd_rs    (lcd_rs),
    .lcd_rw    (lcd_rw),
    .lcd_en    (lcd_en),
    .lcd_db_out(lcd_db_out),
    .lcd_db_oe (lcd_db_oe),
    .lcd_db_in (lcd_db_in)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_WAKE;
      wake_cnt     <= WCW'(WAKE_CYC - 1);
      step         <= 3'd0;
      issued       <= 1'b0;
      cur_byte     <= 8'h00;
      cur_rs       <= 1'b0;
      busy_hi      <= 1'b0;
      poll_cnt     <= '0;
      init_done    <= 1'b0;
      busy_timeout <= 1'b0;
    end else begin
      if (start)     issued <= 1'b1;
      if (xfer_done) issued <= 1'b0;
      case (state)
        ST_WAKE: begin
          if (wake_cnt == '0) state <= ST_WAKE_WR;
          else                wake_cnt <= wake_cnt - 1'b1;
        end
        ST_WAKE_WR: begin
          if (xfer_done) begin
            if (step == 3'(WAKE_WRITES - 1)) begin
              step     <= 3'd0;
              cur_byte <= cfg_byte(3'd0);
              cur_rs   <= 1'b0;
              poll_cnt <= '0;
              state    <= ST_POLL_HI;
            end else begin
              step     <= step + 3'd1;
              wake_cnt <= WCW'(WAKE_CYC - 1);
              state    <= ST_WAKE;
            end
          end
        end
        ST_POLL_HI: begin
          if (xfer_done) begin
            busy_hi <= rd_nib[3];
            state   <= ST_POLL_LO;
          end
        end
        ST_POLL_LO: begin
          if (xfer_done) begin
            if (!busy_hi) begin
              state <= ST_WR_HI;
            end else if (poll_cnt == PCW'(POLL_LIMIT - 1)) begin
              busy_timeout <= 1'b1;
              state        <= ST_WR_HI;
            end else begin
              poll_cnt <= poll_cnt + 1'b1;
              state    <= ST_POLL_HI;
            end
          end
        end
        ST_WR_HI: begin
          if (xfer_done) state <= ST_WR_LO;
        end
        ST_WR_LO: begin
          if (xfer_done) begin
            if (!init_done && step != 3'(CFG_BYTES - 1)) begin
              step     <= step + 3'd1;
              cur_byte <= cfg_byte(step + 3'd1);
              poll_cnt <= '0;
              state    <= ST_POLL_HI;
            end else begin
              init_done <= 1'b1;
              state     <= ST_IDLE;
            end
          end
        end
        default: begin
          if (host_valid) begin
            cur_byte <= host_byte;
            cur_rs   <= host_is_data;
            poll_cnt <= '0;
            state    <= ST_POLL_HI;
          end
        end
      endcase
    end
  end

  // R6: host side opens only after the power-on sequence
  assert_ready_after_init_R6: assert property (@(posedge clk) disable iff (rst)
    host_ready |-> init_done);

  // R6: an accepted byte closes the handshake on the next clock
  assert_accept_closes_R6: assert property (@(posedge clk) disable iff (rst)
    (host_valid && host_ready) |=> !host_ready);

  // R9: the timeout flag is sticky
  assert_timeout_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    busy_timeout |=> busy_timeout);

  // R1: no read cycle during the wake-up phase
  assert_no_read_in_wake_R1: assert property (@(posedge clk) disable iff (rst)
    ((state == ST_WAKE) || (state == ST_WAKE_WR)) |-> !lcd_rw);

endmodule

// File: tb/tb_lcd_nibble_seq.sv
module tb_lcd_nibble_seq;

  localparam int WAKE  = 20;
  localparam int SETUP = 2;
  localparam int PULSE = 3;
  localparam int HOLD  = 1;
  localparam int LIM   = 4;

  logic       clk = 1'b0;
  logic       rst;
  logic       host_valid, host_ready, host_is_data;
  logic [7:0] host_byte;
  logic       init_done, busy_timeout;
  logic       lcd_rs, lcd_rw, lcd_en, lcd_db_oe;
  logic [3:0] lcd_db_out, lcd_db_in;

  always #2 clk = ~clk;

  lcd_nibble_seq #(
    .WAKE_CYC  (WAKE),
    .SETUP_CYC (SETUP),
    .PULSE_CYC (PULSE),
    .HOLD_CYC  (HOLD),
    .POLL_LIMIT(LIM)
  ) dut (
    .clk         (clk),
    .rst         (rst),
    .host_valid  (host_valid),
    .host_ready  (host_ready),
    .host_is_data(host_is_data),
    .host_byte   (host_byte),
    .init_done   (init_done),
    .busy_timeout(busy_timeout),
    .lcd_rs      (lcd_rs),
    .lcd_rw      (lcd_rw),
    .lcd_en      (lcd_en),
    .lcd_db_out  (lcd_db_out),
    .lcd_db_oe   (lcd_db_oe),
    .lcd_db_in   (lcd_db_in)
  );

  int tests = 0;
  int fails = 0;
  int cyc   = 0;

  // expected item: {wake, read, rs, nibble}
  logic [6:0] exp_q[$];

  // display model: busy for busy_left poll pairs
  int   busy_left = 0;
  logic rd_second = 1'b0;
  assign lcd_db_in = rd_second ? 4'h6 : {(busy_left > 0), 3'b001};

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic push_byte(input bit rs, input logic [7:0] b, input int busy);
    int pairs;
    pairs = (busy >= LIM) ? LIM : busy + 1;
    for (int i = 0; i < 2 * pairs; i++) exp_q.push_back({1'b0, 1'b1, 1'b0, 4'h0});
    exp_q.push_back({1'b0, 1'b0, rs, b[7:4]});
    exp_q.push_back({1'b0, 1'b0, rs, b[3:0]});
  endtask

  task automatic send(input bit rs, input logic [7:0] b, input int busy);
    push_byte(rs, b, busy);
    busy_left = busy;
    @(negedge clk);
    while (!host_ready) @(negedge clk);
    host_valid   = 1'b1;
    host_is_data = rs;
    host_byte    = b;
    @(negedge clk);
    check(!host_ready, "R6", "ready after accept", host_ready, 0);
    host_valid = 1'b0;
    while (exp_q.size() != 0 || !host_ready) @(negedge clk);
  endtask

  always @(posedge clk) if (!rst) cyc++;

  // monitor: pops expected items at each enable rise
  logic       prev_en = 1'b0;
  logic [6:0] bus_q = '0;
  logic [6:0] hold_bus = '0;
  int         stable_cnt = 0, high_cnt = 0, last_fall = 0, since = 0;
  bit         watch = 0;

  always @(negedge clk) begin
    logic [6:0] bus_now;
    logic [6:0] e;
    bus_now = {lcd_rs, lcd_rw, lcd_db_out, lcd_db_oe};
    if (!rst) begin
      if (bus_now == bus_q) stable_cnt++;
      else                  stable_cnt = 0;
      if (lcd_en && !prev_en) begin
        watch = 0;
        check(stable_cnt >= SETUP, "R8", "setup clocks", stable_cnt, SETUP);
        if (exp_q.size() == 0) begin
          check(0, "R6", "unexpected bus cycle", int'(bus_now), 0);
        end else begin
          e = exp_q.pop_front();
          check(lcd_rw == e[5], "R4", "cycle kind (1 read)", lcd_rw, e[5]);
          check(lcd_rs == e[4], "R5", "register select", lcd_rs, e[4]);
          if (e[5]) begin
            check(lcd_db_oe == 1'b0, "R7", "oe in read", lcd_db_oe, 0);
          end else begin
            check(lcd_db_oe == 1'b1, "R7", "oe in write", lcd_db_oe, 1);
            check(lcd_db_out == e[3:0], "R3", "written nibble", lcd_db_out, e[3:0]);
          end
          if (e[6]) check(cyc - last_fall >= WAKE, "R1", "wake gap", cyc - last_fall, WAKE);
        end
        high_cnt = 1;
      end else if (lcd_en) begin
        high_cnt++;
      end
      if (!lcd_en && prev_en) begin
        check(high_cnt == PULSE, "R8", "enable width", high_cnt, PULSE);
        last_fall = cyc;
        watch     = 1;
        since     = 1;
        hold_bus  = bus_now;
        if (lcd_rw) begin
          if (rd_second && busy_left > 0) busy_left--;
          rd_second = !rd_second;
        end
      end else if (watch) begin
        if (bus_now != hold_bus) begin
          check(since >= HOLD, "R8", "hold clocks", since, HOLD);
          watch = 0;
        end else begin
          since++;
        end
      end
    end
    bus_q   = bus_now;
    prev_en = lcd_en;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst          = 1'b1;
    host_valid   = 1'b0;
    host_is_data = 1'b0;
    host_byte    = 8'h00;
    busy_left    = 2;
    // R1, R2: wake-up nibbles; R3: configuration bytes (0x28 sees two busy pairs)
    for (int i = 0; i < 3; i++) exp_q.push_back({1'b1, 1'b0, 1'b0, 4'h3});
    exp_q.push_back({1'b1, 1'b0, 1'b0, 4'h2});
    push_byte(1'b0, 8'h28, 2);
    push_byte(1'b0, 8'h08, 0);
    push_byte(1'b0, 8'h01, 0);
    push_byte(1'b0, 8'h06, 0);
    push_byte(1'b0, 8'h0F, 0);

    repeat (3) @(negedge clk);
    // R10 reset state
    check(lcd_en == 1'b0,       "R10", "lcd_en in reset", lcd_en, 0);
    check(lcd_db_oe == 1'b0,    "R10", "oe in reset", lcd_db_oe, 0);
    check(host_ready == 1'b0,   "R10", "ready in reset", host_ready, 0);
    check(init_done == 1'b0,    "R10", "init_done in reset", init_done, 0);
    check(busy_timeout == 1'b0, "R10", "timeout in reset", busy_timeout, 0);
    rst = 1'b0;

    // R6: a byte offered during initialization is ignored
    repeat (10) @(negedge clk);
    host_valid   = 1'b1;
    host_is_data = 1'b1;
    host_byte    = 8'hEE;
    repeat (20) @(negedge clk);
    check(host_ready == 1'b0, "R6", "ready during init", host_ready, 0);
    host_valid = 1'b0;

    while (!init_done) @(negedge clk);
    check(exp_q.size() == 0, "R3", "init items left", exp_q.size(), 0);
    check(host_ready == 1'b1, "R6", "ready after init", host_ready, 1);

    send(1'b0, 8'h80, 0);     // R5 address command, rs low
    send(1'b1, 8'h48, 1);     // R5 data, one busy pair
    send(1'b1, 8'h69, 0);
    send(1'b0, 8'hC0, 0);     // R5 second-line address
    send(1'b1, 8'h21, LIM-1); // R9 one below the limit
    check(busy_timeout == 1'b0, "R9", "no timeout below limit", busy_timeout, 0);
    send(1'b1, 8'h5A, 10);    // R9 limit reached, byte still written
    check(busy_timeout == 1'b1, "R9", "timeout set", busy_timeout, 1);
    send(1'b1, 8'hA5, 0);
    check(busy_timeout == 1'b1, "R9", "timeout sticky", busy_timeout, 1);

    repeat (30) @(negedge clk);
    check(exp_q.size() == 0, "R4", "items left at end", exp_q.size(), 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule